// File: doc/BRIEF.md
# Timer Capture Unit with Prescaled Edges

This block samples an asynchronous input pin and copies the current value of a free-running 16-bit timer into a capture register whenever a selected pin event occurs. The event can be a falling edge, a rising edge, every fourth rising edge or every sixteenth rising edge. A 4-bit mode input selects the event, and any mode code outside the four legal values turns capture off.

Each capture sets a sticky interrupt flag. The flag stays set until a one-cycle clear strobe arrives. If a new capture arrives before software has read the old value, the new value replaces the old one and nothing reports the loss.

The pin passes through a two-flop synchronizer and then an edge detector. A small counter divides the rising edges for the two prescaled modes. Software reads the timer value at the moment of the qualified edge in the capture register, which is held between events.

Top module: `timer_capture_unit`

## Requirements
- R1: A capture loads all 16 bits of `timer_i`. Because the pin passes through two synchronizer flops, the register takes the timer value present just before the third rising clock edge after the pin changes. That value is visible on `cap_val_o` after that edge.
- R2: With `mode_i` = 4'b0100, every falling edge of the pin causes a capture.
- R3: With `mode_i` = 4'b0101, every rising edge of the pin causes a capture.
- R4: With `mode_i` = 4'b0110, only the 4th, 8th, 12th and later multiples of four rising edges, counted from the moment the mode was selected, cause a capture.
- R5: With `mode_i` = 4'b0111, only every 16th rising edge, counted from the moment the mode was selected, causes a capture.
- R6: Any other `mode_i` value disables capture. Pin edges then leave both `cap_val_o` and `flag_o` unchanged.
- R7: Each capture sets `flag_o` on the capture edge. The flag stays set until a cycle with `flag_clr_i` high and no capture, and it reads 0 from the next cycle.
- R8: When a capture and `flag_clr_i` occur in the same cycle, the capture wins and `flag_o` stays 1.
- R9: A later capture overwrites `cap_val_o` even when the flag is still set. Between captures the register holds its value.
- R10: The rising-edge divide counter returns to zero whenever `mode_i` changes or capture is disabled. Edges counted before the change therefore do not count toward the next prescaled capture.
- R11: While `rst_ni` is low, `cap_val_o` reads 0 and `flag_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous event pin |
| timer_i | input | 16 | Free-running timer value |
| mode_i | input | 4 | Event selection code |
| flag_clr_i | input | 1 | One-cycle clear strobe for the flag |
| cap_val_o | output | 16 | Captured timer value |
| flag_o | output | 1 | Sticky capture flag |

## Verification
The hardest case to reach is a flag clear that lands in exactly the cycle in which a synchronized edge completes a capture. The bench uses a timer that steps at every falling clock edge. It raises the pin on a falling clock edge and counts two rising clock edges. It then asserts the clear for exactly the third rising clock edge, which is the edge that performs the capture. A second awkward case is a mode change in the middle of a prescaled count. The bench leaves two rising edges counted, switches directly to a different prescaled mode, and returns. It then shows that four more rising edges are needed before the next capture.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  typedef enum logic [3:0] {
    MODE_FALL    = 4'b0100,
    MODE_RISE    = 4'b0101,
    MODE_RISE4   = 4'b0110,
    MODE_RISE16  = 4'b0111
  } cap_mode_e;

  localparam int unsigned DIV_W = 4;

  function automatic logic mode_valid(input logic [3:0] m);
    return (m == MODE_FALL) || (m == MODE_RISE) ||
           (m == MODE_RISE4) || (m == MODE_RISE16);
  endfunction

  function automatic logic mode_prescaled(input logic [3:0] m);
    return (m == MODE_RISE4) || (m == MODE_RISE16);
  endfunction

  // terminal count of the divide counter for a prescaled mode
  function automatic logic [DIV_W-1:0] div_last(input logic [3:0] m);
    return (m == MODE_RISE16) ? DIV_W'(15) : DIV_W'(3);
  endfunction

endpackage

// File: rtl/tcu_sync.sv
module tcu_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tcu_qualify.sv
module tcu_qualify
  import tcu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_i,
  input  logic [3:0] mode_i,
  output logic       evt_o
);

  logic             prev_q;
  logic             rise, fall;
  logic [3:0]       mode_q;
  logic             mode_chg;
  logic [DIV_W-1:0] cnt_q;
  logic             div_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      mode_q <= 4'd0;
    end else begin
      prev_q <= sig_i;
      mode_q <= mode_i;
    end
  end

  assign rise     = sig_i & ~prev_q;
  assign fall     = ~sig_i & prev_q;
  assign mode_chg = (mode_i != mode_q);
  assign div_hit  = rise && (cnt_q == div_last(mode_i));

  // divide counter, cleared on any mode change or non-prescaled mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (mode_chg || !mode_prescaled(mode_i)) cnt_q <= '0;
    else if (div_hit)                          cnt_q <= '0;
    else if (rise)                             cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      MODE_FALL:   evt_o = fall;
      MODE_RISE:   evt_o = rise;
      MODE_RISE4,
      MODE_RISE16: evt_o = div_hit && !mode_chg;
      default:     evt_o = 1'b0;
    endcase
  end

  assert_cnt_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (cnt_q == '0));

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RISE4) |-> (cnt_q <= DIV_W'(3)));

  assert_evt_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (sig_i != prev_q));

endmodule

// File: rtl/tcu_capture.sv
module tcu_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic [W-1:0] timer_i,
  input  logic         clr_i,
  output logic [W-1:0] cap_o,
  output logic         flag_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_o <= '0;
    else if (evt_i) cap_o <= timer_i;
  end

  // capture beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (evt_i)   flag_o <= 1'b1;
    else if (clr_i)   flag_o <= 1'b0;
  end

  assert_flag_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_o);

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  assert_clr_collide_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && clr_i) |=> flag_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(cap_o));

endmodule

// File: rtl/timer_capture_unit.sv
module timer_capture_unit
  import tcu_pkg::*;
#(
  parameter int unsigned TMR_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [TMR_W-1:0] timer_i,
  input  logic [3:0]       mode_i,
  input  logic             flag_clr_i,
  output logic [TMR_W-1:0] cap_val_o,
  output logic             flag_o
);

  logic pin_s;
  logic cap_evt;

  tcu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  tcu_qualify u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (pin_s),
    .mode_i(mode_i),
    .evt_o (cap_evt)
  );

  tcu_capture #(.W(TMR_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (cap_evt),
    .timer_i(timer_i),
    .clr_i  (flag_clr_i),
    .cap_o  (cap_val_o),
    .flag_o (flag_o)
  );

  assert_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_valid(mode_i) |-> !cap_evt);

  assert_disabled_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_valid(mode_i) && !flag_clr_i) |=> ($stable(cap_val_o) && $stable(flag_o)));

endmodule

// File: tb/timer_capture_unit_test.sv
module timer_capture_unit_test;

  typedef struct packed {
    logic [3:0] mode;
    logic [7:0] pulses;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'b0101, 8'd3},   // R3, R9 overwrite
    '{4'b0100, 8'd2},   // R2
    '{4'b0110, 8'd3},   // R4 no capture yet
    '{4'b0110, 8'd4},   // R4
    '{4'b0110, 8'd9},   // R4
    '{4'b0111, 8'd15},  // R5 none
    '{4'b0111, 8'd16},  // R5
    '{4'b0111, 8'd33},  // R5
    '{4'b0000, 8'd3},   // R6
    '{4'b1101, 8'd2}    // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] timer = 16'hFFF0;
  logic [3:0]  mode = 4'd0;
  logic        clr = 1'b0;
  logic [15:0] cap_val;
  logic        flag;

  int          checks = 0;
  int          errors = 0;
  logic [15:0] exp_val = 16'h0;
  logic        exp_flag = 1'b0;
  int          rise_cnt = 0;
  logic [15:0] t;

  always #5 clk = ~clk;
  always @(negedge clk) timer <= timer + 16'd1;

  timer_capture_unit uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pin_i     (pin),
    .timer_i   (timer),
    .mode_i    (mode),
    .flag_clr_i(clr),
    .cap_val_o (cap_val),
    .flag_o    (flag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_pulse(input logic [3:0] m);
    @(negedge clk); pin = 1'b1; #1 t = timer;
    rise_cnt++;
    if (m == 4'b0101 || (m == 4'b0110 && rise_cnt % 4 == 0) ||
        (m == 4'b0111 && rise_cnt % 16 == 0)) begin
      exp_val = t + 16'd2; exp_flag = 1'b1;
    end
    repeat (4) @(posedge clk);
    @(negedge clk); pin = 1'b0; #1 t = timer;
    if (m == 4'b0100) begin
      exp_val = t + 16'd2; exp_flag = 1'b1;
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk); mode = 4'd0;
    repeat (2) @(negedge clk);
    mode = m; rise_cnt = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    exp_flag = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R11 cap", cap_val, 16'h0);
    check("R11 flag", {15'd0, flag}, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      set_mode(VECS[i].mode);
      clear_flag();
      for (int p = 0; p < int'(VECS[i].pulses); p++) do_pulse(VECS[i].mode);
      @(negedge clk); #1;
      check($sformatf("R1 vec%0d val", i), cap_val, exp_val);
      check($sformatf("R7 vec%0d flag", i), {15'd0, flag}, {15'd0, exp_flag});
    end

    // R7: flag sticky, then cleared
    set_mode(4'b0101);
    clear_flag();
    do_pulse(4'b0101);
    repeat (20) @(negedge clk);
    #1 check("R7 sticky", {15'd0, flag}, 16'd1);
    clear_flag();
    @(negedge clk); #1;
    check("R7 cleared", {15'd0, flag}, 16'd0);
    check("R9 held", cap_val, exp_val);

    // R8: clear in the capture cycle
    @(negedge clk); pin = 1'b1; #1 t = timer;
    @(negedge clk);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    #1;
    check("R8 flag", {15'd0, flag}, 16'd1);
    check("R8 val", cap_val, t + 16'd2);
    exp_val = t + 16'd2; exp_flag = 1'b1;
    @(negedge clk); pin = 1'b0;
    repeat (4) @(negedge clk);

    // R10: mode change mid-count restarts the divider
    set_mode(4'b0110);
    clear_flag();
    do_pulse(4'b0110);
    do_pulse(4'b0110);
    @(negedge clk); mode = 4'b0111;
    repeat (2) @(negedge clk);
    mode = 4'b0110; rise_cnt = 0;
    repeat (2) @(negedge clk);
    do_pulse(4'b0110);
    do_pulse(4'b0110);
    @(negedge clk); #1;
    check("R10 no early capture", {15'd0, flag}, 16'd0);
    do_pulse(4'b0110);
    do_pulse(4'b0110);
    @(negedge clk); #1;
    check("R10 flag after 4", {15'd0, flag}, 16'd1);
    check("R10 val", cap_val, exp_val);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule